// File: doc/BRIEF.md
# Pixel Word Two-Lane Serializer

The serializer takes one 16-bit pixel word per pixel period and sends it out on two one-bit lanes. Each word is cut into eight two-bit slots. A one-cycle pixel-start pulse marks each pixel period. On that pulse the block captures the incoming word into a short delay line. It also loads the word that entered four periods earlier and starts sending it from slot 0.

All logic runs on one fast clock. Each fast cycle is one half-period of the pixel clock that a receiver would see. In single-rate mode a slot lasts one full pixel-clock period, which is two fast cycles, so a word takes 16 fast cycles. In double-rate mode a slot changes on every pixel-clock edge, which is every fast cycle, so a word takes 8 fast cycles.

Two bit arrangements can be selected at run time: interleaved odd/even bits, or high byte on one lane and low byte on the other. The rate mode and the arrangement are both taken at the pixel-start pulse, so they apply to a whole word. An output-enable signal tells the pad ring when the lanes must float.

The slot sequencer is a three-state machine:

| State | Meaning |
|---|---|
| `SER_WAIT` | After reset, before the first pulse. |
| `SER_SHIFT` | Slots are being sent. |
| `SER_DONE` | The last slot has been sent and no new pulse has arrived. |

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| start | `SER_WAIT` | `SER_SHIFT` | Pixel-start pulse. |
| step | `SER_SHIFT` | `SER_SHIFT` | Slot advance. |
| restart | `SER_SHIFT` | `SER_SHIFT` | Pixel-start pulse before slot 7 ends. |
| finish | `SER_SHIFT` | `SER_DONE` | Slot 7 ends with no pulse. |
| resume | `SER_DONE` | `SER_SHIFT` | Pixel-start pulse. |

Top module: `px_lane_serializer`

## Requirements
- R1: After reset both lanes read 0 until the first pixel-start pulse is taken.
- R2: With `split_order`=0 (interleaved), slot k (k = 0..7) carries bit 15-2k on `lane_hi` and bit 14-2k on `lane_lo`. Slot 0 is sent first.
- R3: With `split_order`=1 (byte split), slot k carries bit 15-k on `lane_hi` and bit 7-k on `lane_lo`.
- R4: With `dbl_rate`=0, each slot is held for two fast cycles. Slot 0 is visible in the cycle after the edge that samples the pulse, so a word spans 16 fast cycles.
- R5: With `dbl_rate`=1, the slot advances on every fast cycle, so a word spans 8 fast cycles.
- R6: The word presented with pulse number n is sent after pulse number n+4. The words sent after the first four pulses are zero.
- R7: `lane_oe` equals `lane_en` in the same cycle. When `lane_en` is 0 the lanes are to be floated.
- R8: A pixel-start pulse that arrives before slot 7 has ended aborts the current word. The new word starts at slot 0.
- R9: A change of `split_order` between pulses has no effect on the word being sent.
- R10: If slot 7 ends with no new pulse, both lanes read 0 until the next pulse.
- R11: A change of `dbl_rate` between pulses has no effect on the slot timing of the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the pixel-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_start | input | 1 | One-cycle pixel-period start pulse |
| word_in | input | 16 | Conversion result, sampled with `pix_start` |
| split_order | input | 1 | 0 interleaved, 1 high/low byte split |
| dbl_rate | input | 1 | 0 single-rate, 1 double-rate |
| lane_en | input | 1 | Lane drive enable |
| lane_hi | output | 1 | Upper output lane |
| lane_lo | output | 1 | Lower output lane |
| lane_oe | output | 1 | Lane output enable for the pad ring |

## Verification
The hardest situations to reach are those where the controls or the pulse change while a word is still being sent. Examples are an early pulse that cuts a word short, and an order or rate input that flips partway through the slots.

The driver reaches these cases directly. It shortens a pixel period to 10 fast cycles, and in chosen periods it flips `split_order` and `dbl_rate` three cycles after the pulse. The expected word keeps the settings taken at the pulse.

Long periods are also driven, so that the idle state after slot 7 can be observed. The monitor rebuilds every complete word from both lanes and compares it with the word submitted four pulses earlier.

// File: rtl/px_ser_pkg.sv
package px_ser_pkg;

    typedef enum logic [1:0] {
        SER_WAIT  = 2'd0,
        SER_SHIFT = 2'd1,
        SER_DONE  = 2'd2
    } ser_state_e;

endpackage

// File: rtl/px_word_delay.sv
module px_word_delay #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)        stage[0] <= '0;
                    else if (shift_en) stage[0] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)        stage[g] <= '0;
                    else if (shift_en) stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage[DEPTH-1];

    // R6: the head stage takes the word presented with the pulse
    assert_head_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (stage[0] == $past(din)));

    // R6: with no pulse the delay line does not move
    assert_line_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(dout));

endmodule

// File: rtl/px_slot_fsm.sv
module px_slot_fsm
    import px_ser_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dbl_in,
    output ser_state_e        state_o,
    output logic [SLOT_W-1:0] slot_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    ser_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q,  slot_d;
    logic              phase_q, phase_d;
    logic              dbl_q,   dbl_d;
    logic              step;

    // One slot per fast cycle at double rate, one per two cycles otherwise.
    assign step = dbl_q | phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SER_WAIT;
            slot_q  <= '0;
            phase_q <= 1'b0;
            dbl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            phase_q <= phase_d;
            dbl_q   <= dbl_d;
        end
    end

    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        phase_d = 1'b0;
        dbl_d   = dbl_q;
        unique case (state_q)
            SER_WAIT, SER_DONE: begin
                // start / resume
                if (start) begin
                    state_d = SER_SHIFT;
                    slot_d  = '0;
                    dbl_d   = dbl_in;
                end
            end
            SER_SHIFT: begin
                if (start) begin
                    // restart
                    slot_d = '0;
                    dbl_d  = dbl_in;
                end else if (step && slot_q == LAST_SLOT) begin
                    // finish
                    state_d = SER_DONE;
                    slot_d  = '0;
                end else begin
                    // step
                    phase_d = ~phase_q;
                    if (step) slot_d = slot_q + SLOT_W'(1);
                end
            end
            default: state_d = SER_WAIT;
        endcase
    end

    assign state_o = state_q;
    assign slot_o  = slot_q;

    // R8: a pulse always reframes to slot 0
    assert_restart_slot0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == SER_SHIFT && slot_q == '0));

    // R5: double rate moves one slot per cycle
    assert_double_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SER_SHIFT && dbl_q && !start && slot_q != LAST_SLOT)
        |=> (slot_q == $past(slot_q) + SLOT_W'(1)));

    // R4: single rate holds a slot on the first half
    assert_single_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SER_SHIFT && !dbl_q && !phase_q && !start)
        |=> ($stable(slot_q) && state_q == SER_SHIFT));

    // R10: the end of the last slot without a pulse leads to idle
    assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SER_SHIFT && slot_q == LAST_SLOT && step && !start)
        |=> (state_q == SER_DONE));

    // R11: the rate is latched only at a pulse
    assert_rate_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(dbl_q));

endmodule

// File: rtl/px_lane_mux.sv
module px_lane_mux #(
    parameter int WIDTH  = 16,
    parameter int SLOTS  = WIDTH / 2,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic [WIDTH-1:0]  word,
    input  logic [SLOT_W-1:0] slot,
    input  logic              split,
    input  logic              active,
    output logic              hi,
    output logic              lo
);
    localparam int HALF = WIDTH / 2;

    logic [SLOTS-1:0] hi_ilv, lo_ilv, hi_byt, lo_byt;

    generate
        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            assign hi_ilv[k] = word[WIDTH-1-2*k];
            assign lo_ilv[k] = word[WIDTH-2-2*k];
            assign hi_byt[k] = word[WIDTH-1-k];
            assign lo_byt[k] = word[HALF-1-k];
        end
    endgenerate

    always_comb begin
        if (!active) begin
            hi = 1'b0;
            lo = 1'b0;
        end else if (split) begin
            hi = hi_byt[slot];
            lo = lo_byt[slot];
        end else begin
            hi = hi_ilv[slot];
            lo = lo_ilv[slot];
        end
    end

endmodule

// File: rtl/px_lane_serializer.sv
module px_lane_serializer
    import px_ser_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_start,
    input  logic [WORD_W-1:0] word_in,
    input  logic              split_order,
    input  logic              dbl_rate,
    input  logic              lane_en,
    output logic              lane_hi,
    output logic              lane_lo,
    output logic              lane_oe
);
    localparam int SLOTS  = WORD_W / 2;
    localparam int SLOT_W = $clog2(SLOTS);

    logic [WORD_W-1:0] delayed_word;
    logic [WORD_W-1:0] word_q;
    logic              order_q;
    ser_state_e        seq_state;
    logic [SLOT_W-1:0] seq_slot;

    px_word_delay #(.WIDTH(WORD_W), .DEPTH(LATENCY)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (pix_start),
        .din      (word_in),
        .dout     (delayed_word)
    );

    // The outgoing word and its bit order are both taken at the pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            order_q <= 1'b0;
        end else if (pix_start) begin
            word_q  <= delayed_word;
            order_q <= split_order;
        end
    end

    px_slot_fsm #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (pix_start),
        .dbl_in  (dbl_rate),
        .state_o (seq_state),
        .slot_o  (seq_slot)
    );

    px_lane_mux #(.WIDTH(WORD_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_mux (
        .word   (word_q),
        .slot   (seq_slot),
        .split  (order_q),
        .active (seq_state == SER_SHIFT),
        .hi     (lane_hi),
        .lo     (lane_lo)
    );

    assign lane_oe = lane_en;

    // R9: the bit order never changes between pulses
    assert_order_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_start |=> $stable(order_q));

    // R1 / R10: outside a word both lanes stay low
    assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != SER_SHIFT) |-> (!lane_hi && !lane_lo));

endmodule

// File: tb/px_lane_serializer_test.sv
module px_lane_serializer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_start = 1'b0;
    logic [15:0] word_in = '0;
    logic        split_order = 1'b0;
    logic        dbl_rate = 1'b0;
    logic        lane_en = 1'b1;
    logic        lane_hi, lane_lo, lane_oe;

    always #5 clk = ~clk;

    px_lane_serializer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_start   (pix_start),
        .word_in     (word_in),
        .split_order (split_order),
        .dbl_rate    (dbl_rate),
        .lane_en     (lane_en),
        .lane_hi     (lane_hi),
        .lane_lo     (lane_lo),
        .lane_oe     (lane_oe)
    );

    typedef struct {
        logic [15:0] w;
        bit          ord;
        bit          dbl;
        bit          full;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    logic [15:0] hist[64];
    int          n_sent = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 0;

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Driver: entered just after a rising edge (+2 ns); leaves it the same way.
    task automatic send(input logic [15:0] w, input bit ord, input bit dbl,
                        input int cyc, input bit flip, input string tag);
        exp_t e;
        e.w    = (n_sent >= 4) ? hist[n_sent-4] : 16'h0000;
        e.ord  = ord;
        e.dbl  = dbl;
        e.full = (cyc >= (dbl ? 8 : 16));
        e.tag  = tag;
        hist[n_sent] = w;
        n_sent++;
        expq.push_back(e);
        pix_start   = 1'b1;
        word_in     = w;
        split_order = ord;
        dbl_rate    = dbl;
        @(posedge clk); #2;
        pix_start = 1'b0;
        word_in   = ~w;
        for (int i = 0; i < cyc - 1; i++) begin
            @(posedge clk); #2;
            if (flip && i == 2) begin
                split_order = ~ord;
                dbl_rate    = ~dbl;
            end
        end
    endtask

    // Monitor: rebuilds words from the lanes, sampled at falling edges.
    exp_t        cur;
    bit          mon_act = 0;
    int          mon_n = 0;
    logic [15:0] rebuilt;
    logic        hi_prev, lo_prev;
    bit          hold_bad;

    always @(negedge clk) begin
        int lim;
        int k;
        if (rst_n && mon_act) begin
            lim = cur.dbl ? 8 : 16;
            if (mon_n < lim) begin
                if (cur.dbl || (mon_n % 2 == 0)) begin
                    k = cur.dbl ? mon_n : mon_n / 2;
                    if (cur.ord) begin
                        rebuilt[15-k] = lane_hi;
                        rebuilt[7-k]  = lane_lo;
                    end else begin
                        rebuilt[15-2*k] = lane_hi;
                        rebuilt[14-2*k] = lane_lo;
                    end
                    hi_prev = lane_hi;
                    lo_prev = lane_lo;
                end else if (lane_hi !== hi_prev || lane_lo !== lo_prev) begin
                    hold_bad = 1;
                end
                if (mon_n == lim - 1 && cur.full) begin
                    check(rebuilt === cur.w, cur.tag, rebuilt, cur.w);
                    if (!cur.dbl) check(!hold_bad, "R4 slot held two cycles",
                                        16'(hold_bad), 16'h0);
                end
            end else if (mon_n == lim) begin
                // R10: idle after the last slot with no new pulse
                check(lane_hi === 1'b0 && lane_lo === 1'b0, "R10 idle lanes",
                      {14'h0, lane_hi, lane_lo}, 16'h0);
                mon_act = 0;
            end
            mon_n++;
        end
        if (rst_n && pix_start) begin
            if (expq.size() == 0) begin
                check(1'b0, "scoreboard empty", 16'h0, 16'h1);
            end else begin
                cur      = expq.pop_front();
                mon_act  = 1;
                mon_n    = 0;
                rebuilt  = '0;
                hold_bad = 0;
            end
        end
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: lanes low in reset
        check(lane_hi === 1'b0 && lane_lo === 1'b0, "R1 reset lanes",
              {14'h0, lane_hi, lane_lo}, 16'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: lanes low after reset, before any pulse
        check(lane_hi === 1'b0 && lane_lo === 1'b0, "R1 pre-pulse lanes",
              {14'h0, lane_hi, lane_lo}, 16'h0);
        check(lane_oe === 1'b1, "R7 oe high", {15'h0, lane_oe}, 16'h1);
        @(posedge clk); #2;

        // R6: pipeline fill, the first four words out are zero
        for (int i = 0; i < 4; i++) send(16'(16'h3B1D * (i + 1) + 16'h5A), 0, 0, 16, 0, "R6 fill");
        send(16'hA5C3, 0, 0, 16, 0, "R6 first delayed");
        // R2 with R4: interleaved, single rate
        for (int i = 0; i < 3; i++) send(16'(16'h9E37 * (i + 3)), 0, 0, 16, 0, "R2 interleaved single");
        // R7: lanes float request mid-stream
        lane_en = 1'b0;
        @(negedge clk);
        check(lane_oe === 1'b0, "R7 oe low", {15'h0, lane_oe}, 16'h0);
        @(posedge clk); #2;
        lane_en = 1'b1;
        @(negedge clk);
        check(lane_oe === 1'b1, "R7 oe restored", {15'h0, lane_oe}, 16'h1);
        @(posedge clk); #2;
        // R3: byte split, single rate
        for (int i = 0; i < 4; i++) send(16'(16'hF00F ^ (16'h1111 * i)), 1, 0, 16, 0, "R3 split single");
        // R5: interleaved, double rate
        for (int i = 0; i < 4; i++) send(16'(16'h7B2E + 16'h0C41 * i), 0, 1, 8, 0, "R5 interleaved double");
        // R3 with R5: byte split, double rate
        for (int i = 0; i < 4; i++) send(16'(16'hC3A1 - 16'h0517 * i), 1, 1, 8, 0, "R3 split double");
        // R9 and R11: controls flip mid-word
        send(16'h6D4B, 0, 0, 16, 1, "R9 R11 flip");
        send(16'h1F80, 1, 1, 8, 1, "R9 R11 flip");
        send(16'h8E2A, 0, 0, 16, 1, "R9 R11 flip");
        send(16'h55AA, 1, 1, 8, 1, "R9 R11 flip");
        // R8: early pulse cuts a word, the following ones frame cleanly
        send(16'h0FF0, 0, 0, 10, 0, "R8 cut");
        send(16'h3C3C, 1, 0, 16, 0, "R8 after early pulse");
        send(16'hE1E1, 0, 1, 5, 0, "R8 cut");
        send(16'h2468, 1, 1, 8, 0, "R8 after early pulse");
        // R10: long periods leave idle gaps
        send(16'h1357, 0, 0, 24, 0, "R10 long single");
        send(16'hBEEF, 1, 1, 12, 0, "R10 long double");
        for (int i = 0; i < 4; i++) send(16'h0000, 0, 0, 20, 0, "R10 drain");
        repeat (30) @(posedge clk);
        summary();
    end

endmodule